// File: doc/BRIEF.md
# Stop-Mode Wake-Up Clock Controller

This block manages a low-power stop state in which the main oscillator is switched off. A stop command from the processor freezes all clocks, provided at least one wake-capable interrupt source is enabled above the current processor priority. The processor priority in force at that moment is saved. The first qualifying request restarts the oscillator and the divided peripheral clocks in the same cycle. The CPU and system clock stays gated while a down-counter, shared with the watchdog, runs out a stabilisation delay.

During that wait the counter steps on the divide-by-32 tick, whatever the user has selected as its count source. When the counter's most significant bit reaches 0, the CPU clock returns and the user's tick choice takes effect again. Every request captured from the oscillator restart onward is then handed to a downstream interrupt arbiter, one at a time, highest priority level first.

The tick inputs are one-cycle strobes from a free-running prescaler. The arbiter takes a presented request by pulsing `grant_ack`.

Top module: `stop_wake_ctrl`

## Requirements
- R1: On reset the status reads RUN (code 0), all three clock enables are 1, the counter holds all ones, and no request is presented.
- R2: In RUN, a stop command with at least one source whose wake-capable flag is 1 and whose level is above `cpu_level` moves the block to STOPPED (code 1) on the next edge. In STOPPED all three clock enables are 0, and the counter is loaded with all ones and held.
- R3: A stop command is ignored when no wake-capable source has a level above `cpu_level`. The status stays RUN.
- R4: In STOPPED, a request from a source with wake-capable flag 1 and a level strictly above the saved processor level drives `osc_en` and `periph_clk_en` high in the same cycle. The status becomes WAKING (code 2) on the next edge, and `cpu_clk_en` stays 0.
- R5: In STOPPED, a request from a source that is not wake-capable, or whose level is not above the saved level, changes nothing. It is not captured and is never presented. The saved level, not the live `cpu_level`, decides this.
- R6: In WAKING the counter decreases by one on each `tick_div32` strobe and ignores `tick_div512`, whatever the value of `wdt_sel_slow`.
- R7: `cpu_clk_en` rises on the same edge on which the counter's most significant bit becomes 0. From then on the counter steps on `tick_div512` when `wdt_sel_slow` is 1, and on `tick_div32` when it is 0.
- R8: A further qualifying request during WAKING neither reloads the counter nor restarts the sequence.
- R9: Requests from sources with a non-zero level are captured in WAKING and RUN whatever their wake-capable flag. None is presented while `cpu_clk_en` is 0. Once it is 1, they are presented highest level first, with equal levels taken lowest index first, and `grant_ack` removes the presented one.
- R10: The status reads RUN_PENDING (code 3) while the CPU clock runs and a captured request waits. It reads RUN (code 0) once none waits.
- R11: A source with level 0 is never captured or presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_cmd | input | 1 | One-cycle stop command from the processor |
| irq_req | input | NSRC | Interrupt request strobes, one per source |
| wake_ok | input | NSRC | Per-source flag: the source can raise a request while clocks are stopped |
| src_level | input | NSRC*PRIO_W | Packed priority levels, source i in bits [i*PRIO_W +: PRIO_W] |
| cpu_level | input | PRIO_W | Current processor priority level |
| tick_div32 | input | 1 | Divide-by-32 prescaler strobe |
| tick_div512 | input | 1 | Divide-by-512 prescaler strobe |
| wdt_sel_slow | input | 1 | User count-source select: 1 selects the /512 tick, 0 the /32 tick |
| grant_ack | input | 1 | Arbiter accepts the presented request |
| osc_en | output | 1 | Main oscillator enable |
| periph_clk_en | output | 1 | Enable for the divided peripheral clocks |
| cpu_clk_en | output | 1 | CPU and system clock enable |
| wdt_count | output | WDT_W | Shared watchdog / stabilisation counter value |
| grant_valid | output | 1 | A captured request is presented |
| grant_id | output | IDW | Index of the presented request |
| status | output | 2 | 0 RUN, 1 STOPPED, 2 WAKING, 3 RUN_PENDING |

## Verification
Some rules are checked by the assertions on every cycle. The CPU clock is never on while stopped, and it rises only with the counter's top bit clear. Every /32 strobe during the wait takes exactly one count, and nothing else moves the counter then. Nothing is presented while the CPU clock is gated, and no level-0 source is ever presented. A lit oscillator enable in STOPPED always leads to WAKING.

Other behaviour needs the bench's scenarios. These are the refused stop command and the requests dropped for low level or no wake capability, judged against the saved level. They also include the exact drain order of requests captured during the wait, the ties between equal levels, and the return to the user's slow tick after the wait.

// File: rtl/swk_pkg.sv
// Package: shared encodings for the stop-mode wake-up controller.
// Assumes: two-bit status bus consumed by software-visible logic elsewhere.
package swk_pkg;

    // Internal sequencing state of the controller.
    typedef enum logic [1:0] {
        CS_RUN     = 2'd0,
        CS_STOPPED = 2'd1,
        CS_WAKING  = 2'd2
    } core_state_t;

    // Status codes driven on the status port.
    localparam logic [1:0] STAT_RUN     = 2'd0;
    localparam logic [1:0] STAT_STOPPED = 2'd1;
    localparam logic [1:0] STAT_WAKING  = 2'd2;
    localparam logic [1:0] STAT_PENDING = 2'd3;

endpackage

// File: rtl/swk_qualify.sv
// Module: per-source qualification of requests.
// What it does: decides which sources permit a stop, which requests wake
// the block from stop, and which requests may be captured while running.
// Assumes: levels packed NSRC x PRIO_W, level 0 means disabled.
module swk_qualify #(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 3
) (
    input  logic [NSRC-1:0]        irq_req,
    input  logic [NSRC-1:0]        wake_ok,
    input  logic [NSRC*PRIO_W-1:0] src_level,
    input  logic [PRIO_W-1:0]      cpu_level,
    input  logic [PRIO_W-1:0]      saved_level,
    output logic                   stop_allowed,
    output logic [NSRC-1:0]        wake_vec,
    output logic [NSRC-1:0]        live_vec
);

    logic [NSRC-1:0] enabled_for_stop;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic [PRIO_W-1:0] lvl;
        assign lvl = src_level[i*PRIO_W +: PRIO_W];
        // Source can wake the block, judged against the live processor level.
        assign enabled_for_stop[i] = wake_ok[i] && (lvl > cpu_level);
        // Request wakes the block, judged against the level saved at stop.
        assign wake_vec[i]         = irq_req[i] && wake_ok[i] && (lvl > saved_level);
        // Request is capturable while clocks run: any non-zero level.
        assign live_vec[i]         = irq_req[i] && (lvl != '0);
    end

    assign stop_allowed = |enabled_for_stop;

endmodule

// File: rtl/swk_wdt.sv
// Module: shared watchdog / stabilisation down-counter.
// What it does: loads all ones on request, holds while frozen, and otherwise
// decrements on the /32 tick (forced) or on the user-selected tick.
// Reports the step on which the most significant bit clears.
// Assumes: ticks are single-cycle strobes; counter wraps when free running.
module swk_wdt #(
    parameter int WDT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             freeze,
    input  logic             force_fast,
    input  logic             sel_slow,
    input  logic             tick_fast,
    input  logic             tick_slow,
    output logic [WDT_W-1:0] count,
    output logic             msb_clearing
);

    localparam logic [WDT_W-1:0] ALL_ONES = '1;
    localparam logic [WDT_W-1:0] MSB_ONLY = {1'b1, {(WDT_W-1){1'b0}}};

    logic step;

    // Pick the count source: forced /32 during the wait, user choice otherwise.
    always_comb begin
        if (freeze)
            step = 1'b0;
        else if (force_fast)
            step = tick_fast;
        else
            step = sel_slow ? tick_slow : tick_fast;
    end

    // Counter register: reload has priority over stepping.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= ALL_ONES;
        else if (load)
            count <= ALL_ONES;
        else if (step)
            count <= count - 1'b1;
    end

    // The step that takes the count from MSB-only to below it clears the MSB.
    assign msb_clearing = step && !load && (count == MSB_ONLY);

endmodule

// File: rtl/swk_prio_pick.sv
// Module: priority selector over captured requests.
// What it does: returns the captured source with the highest level; among
// equal levels the lowest index wins.
// Assumes: captured sources all have non-zero levels.
module swk_prio_pick #(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 3,
    parameter int IDW    = 3
) (
    input  logic [NSRC-1:0]        pend,
    input  logic [NSRC*PRIO_W-1:0] src_level,
    output logic                   any,
    output logic [IDW-1:0]         pick
);

    logic [PRIO_W-1:0] best;

    // Scan from the top index down so ties fall to the lower index.
    always_comb begin
        best = '0;
        pick = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i] && (src_level[i*PRIO_W +: PRIO_W] >= best)) begin
                best = src_level[i*PRIO_W +: PRIO_W];
                pick = IDW'(i);
            end
        end
    end

    assign any = |pend;

endmodule

// File: rtl/stop_wake_ctrl.sv
// Module: stop-mode wake-up clock controller (top).
// What it does: sequences stop entry, oscillator restart, the stabilisation
// wait on the shared watchdog counter and the release of the CPU clock, and
// presents captured requests to the interrupt arbiter in priority order.
// Assumes: synchronous active-low reset; tick inputs are single-cycle
// strobes; the arbiter pulses grant_ack for one cycle per accepted request.
module stop_wake_ctrl #(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 3,
    parameter int WDT_W  = 12,
    localparam int IDW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   stop_cmd,
    input  logic [NSRC-1:0]        irq_req,
    input  logic [NSRC-1:0]        wake_ok,
    input  logic [NSRC*PRIO_W-1:0] src_level,
    input  logic [PRIO_W-1:0]      cpu_level,
    input  logic                   tick_div32,
    input  logic                   tick_div512,
    input  logic                   wdt_sel_slow,
    input  logic                   grant_ack,
    output logic                   osc_en,
    output logic                   periph_clk_en,
    output logic                   cpu_clk_en,
    output logic [WDT_W-1:0]       wdt_count,
    output logic                   grant_valid,
    output logic [IDW-1:0]         grant_id,
    output logic [1:0]             status
);
    import swk_pkg::*;

    core_state_t       state_q, state_d;
    logic [PRIO_W-1:0] saved_q;
    logic [NSRC-1:0]   pend_q, pend_d;
    logic              stop_allowed;
    logic [NSRC-1:0]   wake_vec, live_vec;
    logic              wake_hit, enter_stop, msb_clearing, pick_any;
    logic [IDW-1:0]    pick_id;

    swk_qualify #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_qual (
        .irq_req      (irq_req),
        .wake_ok      (wake_ok),
        .src_level    (src_level),
        .cpu_level    (cpu_level),
        .saved_level  (saved_q),
        .stop_allowed (stop_allowed),
        .wake_vec     (wake_vec),
        .live_vec     (live_vec)
    );

    swk_wdt #(.WDT_W(WDT_W)) u_wdt (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (enter_stop),
        .freeze       (state_q == CS_STOPPED),
        .force_fast   (state_q == CS_WAKING),
        .sel_slow     (wdt_sel_slow),
        .tick_fast    (tick_div32),
        .tick_slow    (tick_div512),
        .count        (wdt_count),
        .msb_clearing (msb_clearing)
    );

    swk_prio_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDW(IDW)) u_pick (
        .pend      (pend_q),
        .src_level (src_level),
        .any       (pick_any),
        .pick      (pick_id)
    );

    // Wake and stop-entry conditions.
    assign wake_hit   = (state_q == CS_STOPPED) && (|wake_vec);
    assign enter_stop = (state_q == CS_RUN) && stop_cmd && stop_allowed;

    // Next-state logic of the stop / wake sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_RUN:     if (enter_stop)   state_d = CS_STOPPED;
            CS_STOPPED: if (wake_hit)     state_d = CS_WAKING;
            CS_WAKING:  if (msb_clearing) state_d = CS_RUN;
            default:                      state_d = CS_RUN;
        endcase
    end

    // Capture set: only qualifying wake requests while stopped, any enabled otherwise.
    always_comb begin
        pend_d = pend_q;
        if (grant_valid && grant_ack)
            pend_d[grant_id] = 1'b0;
        if (state_q == CS_STOPPED)
            pend_d = pend_d | wake_vec;
        else
            pend_d = pend_d | live_vec;
    end

    // State, saved processor level and capture registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_RUN;
            saved_q <= '0;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            if (enter_stop)
                saved_q <= cpu_level;
        end
    end

    // Clock enables: oscillator and peripherals restart in the wake cycle itself.
    assign osc_en        = (state_q != CS_STOPPED) || wake_hit;
    assign periph_clk_en = (state_q != CS_STOPPED) || wake_hit;
    assign cpu_clk_en    = (state_q == CS_RUN);

    // Hand-off to the arbiter only once the CPU clock runs.
    assign grant_valid = cpu_clk_en && pick_any;
    assign grant_id    = pick_id;

    // Status encoding.
    always_comb begin
        unique case (state_q)
            CS_STOPPED: status = STAT_STOPPED;
            CS_WAKING:  status = STAT_WAKING;
            default:    status = pick_any ? STAT_PENDING : STAT_RUN;
        endcase
    end

endmodule

// File: rtl/swk_checker.sv
// Module: property checker for stop_wake_ctrl, attached by bind.
// What it does: watches the ports for sequencing and counting rules.
// Assumes: status codes 0 RUN, 1 STOPPED, 2 WAKING, 3 RUN_PENDING.
module swk_checker #(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 3,
    parameter int WDT_W  = 12,
    parameter int IDW    = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [1:0]             status,
    input logic                   osc_en,
    input logic                   cpu_clk_en,
    input logic [WDT_W-1:0]       wdt_count,
    input logic                   tick_div32,
    input logic                   grant_valid,
    input logic [IDW-1:0]         grant_id,
    input logic [NSRC*PRIO_W-1:0] src_level
);

    // R2: CPU clock is off whenever the block reports STOPPED.
    assert_cpu_off_in_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd1) |-> !cpu_clk_en);

    // R4: a lit oscillator enable while stopped leads to WAKING.
    assert_wake_follows_osc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd1 && osc_en) |=> (status == 2'd2));

    // R6: each /32 strobe during the wait takes exactly one count.
    assert_wait_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd2 && tick_div32) |=> (wdt_count == $past(wdt_count) - 1'b1));

    // R6: without a /32 strobe the counter holds during the wait.
    assert_wait_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd2 && !tick_div32) |=> $stable(wdt_count));

    // R7: CPU clock returns only with the counter's top bit clear.
    assert_release_msb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk_en) |-> !wdt_count[WDT_W-1]);

    // R8: the wait never falls back to STOPPED.
    assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd2) |=> (status != 2'd1));

    // R9: nothing is presented while the CPU clock is gated.
    assert_no_grant_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> cpu_clk_en);

    // R11: a presented source never has level 0.
    assert_no_level0_R11: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (src_level[grant_id*PRIO_W +: PRIO_W] != '0));

endmodule

bind stop_wake_ctrl swk_checker #(
    .NSRC(NSRC), .PRIO_W(PRIO_W), .WDT_W(WDT_W), .IDW(IDW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .status      (status),
    .osc_en      (osc_en),
    .cpu_clk_en  (cpu_clk_en),
    .wdt_count   (wdt_count),
    .tick_div32  (tick_div32),
    .grant_valid (grant_valid),
    .grant_id    (grant_id),
    .src_level   (src_level)
);

// File: tb/sim_stop_wake_ctrl.sv
// Bench: scoreboard of expected grant order plus directed sequencing checks.
module sim_stop_wake_ctrl;
    localparam int NSRC = 8, PRIO_W = 3, WDT_W = 12, IDW = 3;

    logic clk = 0, rst_n = 0, stop_cmd = 0;
    logic [NSRC-1:0] irq_req = '0, wake_ok = '0;
    logic [NSRC*PRIO_W-1:0] src_level = '0;
    logic [PRIO_W-1:0] cpu_level = '0;
    logic tick_div32 = 0, tick_div512 = 0, wdt_sel_slow = 0, grant_ack = 0;
    logic osc_en, periph_clk_en, cpu_clk_en, grant_valid;
    logic [WDT_W-1:0] wdt_count;
    logic [IDW-1:0] grant_id;
    logic [1:0] status;

    int checks = 0, fails = 0;
    int exp_q[$];
    int exp_id;
    bit early_cpu;

    always #2.5 clk = ~clk;   // 200 MHz

    stop_wake_ctrl u0 (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_irq(input int idx);
        irq_req[idx] = 1'b1;
        step(1);
        irq_req[idx] = 1'b0;
    endtask

    // Monitor: pops the scoreboard whenever a request is presented and accepts it.
    always @(negedge clk) begin
        grant_ack <= 1'b0;
        if (rst_n && grant_valid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R9 unexpected grant actual=%0d expected=none", grant_id);
            end else begin
                exp_id = exp_q.pop_front();
                chk(int'(grant_id) == exp_id, "R9 grant order", int'(grant_id), exp_id);
            end
            grant_ack <= 1'b1;
        end
    end

    // Watchdog for a hung run.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        // levels: s0=5 s1=2 s2=5 s3=0 s4=7 s5=3 s6=1 s7=6
        src_level = {3'd6, 3'd1, 3'd3, 3'd7, 3'd0, 3'd5, 3'd2, 3'd5};
        wake_ok   = 8'b0011_0111;
        step(3);
        rst_n = 1;
        step(1);
        // R1 reset state
        chk(status == 2'd0, "R1 status", status, 0);
        chk(cpu_clk_en && osc_en && periph_clk_en, "R1 enables", {cpu_clk_en, osc_en, periph_clk_en}, 7);
        chk(wdt_count == 12'hFFF, "R1 counter", wdt_count, 12'hFFF);
        chk(!grant_valid, "R1 grant", grant_valid, 0);

        // R3: no wake-capable source above level 7
        cpu_level = 3'd7;
        stop_cmd = 1; step(1); stop_cmd = 0; step(1);
        chk(status == 2'd0 && cpu_clk_en, "R3 stop refused", status, 0);

        // R2: stop accepted at level 4 (s0, s2, s4 qualify)
        cpu_level = 3'd4;
        stop_cmd = 1; step(1); stop_cmd = 0;
        chk(status == 2'd1, "R2 status", status, 1);
        chk(!cpu_clk_en && !osc_en && !periph_clk_en, "R2 enables", {cpu_clk_en, osc_en, periph_clk_en}, 0);
        chk(wdt_count == 12'hFFF, "R2 counter", wdt_count, 12'hFFF);

        // R5: live level lowered, saved level 4 still governs; s1 (2) and s7 (not wake-capable)
        cpu_level = 3'd0;
        irq_req[1] = 1; irq_req[7] = 1;
        #1 chk(!osc_en, "R5 osc stays off", osc_en, 0);
        step(1); irq_req = '0;
        step(1);
        chk(status == 2'd1, "R5 still stopped", status, 1);

        // R4: s0 (level 5, wake-capable) wakes
        wdt_sel_slow = 1;
        irq_req[0] = 1;
        #1 chk(osc_en && periph_clk_en, "R4 same-cycle enables", {osc_en, periph_clk_en}, 3);
        exp_q.push_back(0);
        step(1); irq_req = '0;
        chk(status == 2'd2 && !cpu_clk_en, "R4 waking", status, 2);

        // R6: /32 counts despite slow select; /512 ignored
        tick_div32 = 1; step(1); tick_div32 = 0;
        chk(wdt_count == 12'hFFE, "R6 forced /32 step", wdt_count, 12'hFFE);
        tick_div512 = 1; step(1); tick_div512 = 0;
        chk(wdt_count == 12'hFFE, "R6 /512 ignored", wdt_count, 12'hFFE);

        // R8: another qualifying wake does not reload
        exp_q.push_back(4);
        pulse_irq(4);
        chk(wdt_count == 12'hFFE && status == 2'd2, "R8 no restart", wdt_count, 12'hFFE);

        // R9 / R11: non-wake s6 and s2 captured, level-0 s3 dropped, nothing presented yet
        irq_req[6] = 1; irq_req[2] = 1; irq_req[3] = 1;
        step(1); irq_req = '0;
        chk(!grant_valid, "R9 held while gated", grant_valid, 0);
        // expected drain: s4(7), s0(5), s2(5), s6(1)
        exp_q.delete();
        exp_q.push_back(4); exp_q.push_back(0); exp_q.push_back(2); exp_q.push_back(6);

        // R7: run out the wait
        early_cpu = 0;
        while (wdt_count[WDT_W-1]) begin
            tick_div32 = 1;
            step(1);
            if (wdt_count[WDT_W-1] && cpu_clk_en) early_cpu = 1;
        end
        tick_div32 = 0;
        chk(!early_cpu, "R7 no early release", early_cpu, 0);
        chk(wdt_count == 12'h7FF && cpu_clk_en, "R7 release at MSB clear", wdt_count, 12'h7FF);
        chk(status == 2'd3, "R10 run pending", status, 3);

        // R7: user slow select now applies
        tick_div32 = 1; step(1); tick_div32 = 0;
        chk(wdt_count == 12'h7FF, "R7 /32 ignored after wait", wdt_count, 12'h7FF);
        tick_div512 = 1; step(1); tick_div512 = 0;
        chk(wdt_count == 12'h7FE, "R7 /512 steps after wait", wdt_count, 12'h7FE);

        step(10);
        chk(exp_q.size() == 0, "R9 all drained", exp_q.size(), 0);
        chk(status == 2'd0 && !grant_valid, "R10 back to run", status, 0);

        // R9 tie in RUN: s2 and s0 both level 5, lower index first
        exp_q.push_back(0); exp_q.push_back(2);
        irq_req[0] = 1; irq_req[2] = 1; irq_req[3] = 1;
        step(1); irq_req = '0;
        step(8);
        chk(exp_q.size() == 0, "R9 tie drained", exp_q.size(), 0);
        chk(status == 2'd0, "R11 level-0 never pending", status, 0);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule